// File: doc/BRIEF.md
# FPGA Slave Configuration Port

This block is the front end that loads a programmable device's configuration from outside. An external host drives a configuration clock and presents the bitstream in one of two forms. In serial form the port takes one bit per rising edge. In byte-wide form it takes one byte per edge, and only on edges where three chip selects all agree. Every accepted unit is shifted into a fixed-length configuration store. When the store holds `CFG_BITS` bits, the port raises a done flag and freezes the store.

In serial form the port can sit in a daisy chain. Once its own store is full, the port repeats each further input bit on a chain output, one clock later. Devices further down the chain are loaded from that output. In byte-wide form the chain output carries no stream, so it is held low. A bit-order swap option reverses each byte before it is stored. This lets a host bus wired in the opposite bit order be used without rewriting the file.

The load mode and the swap option are captured while reset is held low. They stay fixed until the next reset. The active-low synchronous reset works as the program input: it clears the store, the count, the done flag and the chain output.

Top module: `cfg_load_port`

## Requirements
- R1: In serial mode (`mode_par_i`=0 at reset), each rising edge before done shifts `ser_din_i` into bit 0 of `cfg_data_o`. Earlier bits move one place toward the MSB.
- R2: In byte mode (`mode_par_i`=1 at reset), a byte is accepted only when `wr_n_i`=0, `cs0_n_i`=0 and `cs1_i`=1 at the edge. The accepted byte enters `cfg_data_o[7:0]`, and earlier data moves up by eight bits.
- R3: In byte mode, an edge on which any of the three selects is inactive leaves `cfg_data_o` and the count unchanged. Loading resumes on the next qualified edge.
- R4: With `swap_i`=1 captured at reset, each accepted byte is stored bit-reversed: `par_din_i[0]` lands in bit 7 of the new low byte and `par_din_i[7]` in bit 0.
- R5: `done_o` is low until `CFG_BITS` bits (serial) or `CFG_BITS/8` bytes (byte mode) have been accepted. It is high from the edge that accepts the last unit and stays high until reset.
- R6: While `done_o` is high, `cfg_data_o` does not change.
- R7: In serial mode, `chain_o` is low until done. After done, `chain_o` shows the `ser_din_i` value sampled at the previous rising edge.
- R8: In byte mode, `chain_o` stays low at all times, whatever `ser_din_i` does.
- R9: `mode_par_i` and `swap_i` are captured only while `rst_n` is low. Changing them after reset has no effect on loading.
- R10: `rst_n` low at a rising edge clears `cfg_data_o`, the count, `done_o` and `chain_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset / program |
| mode_par_i | input | 1 | 1 = byte-wide load, 0 = serial load; captured during reset |
| swap_i | input | 1 | 1 = reverse bit order of each byte; captured during reset |
| ser_din_i | input | 1 | Serial data input |
| par_din_i | input | 8 | Byte-wide data input |
| wr_n_i | input | 1 | Write select, active low |
| cs0_n_i | input | 1 | Chip select 0, active low |
| cs1_i | input | 1 | Chip select 1, active high |
| chain_o | output | 1 | Daisy-chain data output |
| done_o | output | 1 | Configuration load complete |
| cfg_data_o | output | CFG_BITS | Contents of the configuration store |

## Verification
The serial load uses a non-repeating bit pattern, so a dropped, duplicated or reordered bit shows up in the final store. The patterns after done show whether the chain output is delayed by exactly one clock. The byte-mode loads interleave edges where each select is inactive in turn, which tells apart correct qualification from decoding that ignores one select. The same bytes are loaded with and without the swap, so mirrored and unmirrored storage give different results. Changing the mode and swap inputs after reset, and pulsing reset in the middle of a load, show whether these controls are captured only during reset and whether reset fully clears the port.

// File: rtl/cfg_load_pkg.sv
// Package: shared types and helpers for the configuration load port.
// Assumes a byte width of eight bits on the parallel data bus.
package cfg_load_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        MODE_SER = 1'b0,
        MODE_PAR = 1'b1
    } load_mode_e;

    // Mirror the bit order of one byte.
    function automatic logic [BYTE_W-1:0] mirror_byte(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = b[BYTE_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/cfg_mode_latch.sv
// Module: captures the load mode and the byte swap option while reset is low.
// Assumes: the host holds mode and swap steady for at least one edge of reset.
// Both values stay fixed from reset release until the next reset.
module cfg_mode_latch
    import cfg_load_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_par_i,
    input  logic       swap_i,
    output load_mode_e mode_o,
    output logic       swap_o
);

    // Capture the controls during reset; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= mode_par_i ? MODE_PAR : MODE_SER;
            swap_o <= swap_i;
        end
    end

    // R9: the captured controls do not move while out of reset
    a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(mode_o) && $stable(swap_o)));

endmodule

// File: rtl/cfg_front.sv
// Module: input qualification for the configuration port.
// In serial mode every edge carries one bit. In byte mode an edge carries
// a byte only when all three selects agree. Nothing is accepted after done.
// Assumes: the select inputs meet setup and hold to the rising edge.
module cfg_front
    import cfg_load_pkg::*;
(
    input  load_mode_e        mode_i,
    input  logic              swap_i,
    input  logic              done_i,
    input  logic              ser_din_i,
    input  logic [BYTE_W-1:0] par_din_i,
    input  logic              wr_n_i,
    input  logic              cs0_n_i,
    input  logic              cs1_i,
    output logic              accept_o,
    output logic [BYTE_W-1:0] word_o
);

    logic sel_ok;

    // Decide whether this edge carries a unit of configuration data.
    always_comb begin
        sel_ok   = !wr_n_i && !cs0_n_i && cs1_i;
        accept_o = !done_i && ((mode_i == MODE_SER) || sel_ok);
    end

    // Form the data word: a lone bit in serial mode, an optionally mirrored byte otherwise.
    always_comb begin
        if (mode_i == MODE_PAR) begin
            word_o = swap_i ? mirror_byte(par_din_i) : par_din_i;
        end else begin
            word_o = {{(BYTE_W-1){1'b0}}, ser_din_i};
        end
    end

endmodule

// File: rtl/cfg_shift_store.sv
// Module: configuration store with its bit count and done flag.
// Each accepted unit shifts in at the low end: one bit in serial mode,
// one byte in byte mode. Done rises on the edge that fills the store.
// Assumes: CFG_BITS is a multiple of eight and at least sixteen.
module cfg_shift_store
    import cfg_load_pkg::*;
#(
    parameter int CFG_BITS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  load_mode_e          mode_i,
    input  logic                accept_i,
    input  logic [BYTE_W-1:0]   word_i,
    output logic [CFG_BITS-1:0] store_o,
    output logic                done_o
);

    localparam int CW = $clog2(CFG_BITS + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_next;

    // Next bit count for an accepted unit.
    always_comb begin
        cnt_next = cnt_q + ((mode_i == MODE_PAR) ? CW'(BYTE_W) : CW'(1));
    end

    // Shift accepted data in and track completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            done_o  <= 1'b0;
            store_o <= '0;
        end else if (accept_i) begin
            cnt_q <= cnt_next;
            if (mode_i == MODE_PAR) begin
                store_o <= {store_o[CFG_BITS-BYTE_W-1:0], word_i};
            end else begin
                store_o <= {store_o[CFG_BITS-2:0], word_i[0]};
            end
            if (cnt_next == CW'(CFG_BITS)) begin
                done_o <= 1'b1;
            end
        end
    end

    // R5: done, once set, stays set until reset
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

    // R5: the count never passes the store length
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(CFG_BITS));

    // R6: the store is frozen once loading is done
    a_r6_store_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> $stable(store_o));

    // R3: with no accepted unit, the store and count stay put
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> ($stable(store_o) && $stable(cnt_q)));

    // R10: reset clears the count, done flag and store
    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0 && !done_o && store_o == '0));

endmodule

// File: rtl/cfg_chain_out.sv
// Module: daisy-chain output register.
// In serial mode, after done, each input bit is repeated one clock later.
// Before done, and always in byte mode, the output is held low.
// Assumes: done comes from the same clock domain.
module cfg_chain_out
    import cfg_load_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  load_mode_e mode_i,
    input  logic       done_i,
    input  logic       ser_din_i,
    output logic       chain_o
);

    // Register the passthrough bit, or zero when not passing through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_o <= 1'b0;
        end else begin
            chain_o <= (mode_i == MODE_SER && done_i) ? ser_din_i : 1'b0;
        end
    end

    // R7: no passthrough before the port is configured
    a_r7_quiet_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> !chain_o);

    // R8: byte mode never drives the chain
    a_r8_par_chain_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_PAR) |-> !chain_o);

    // R10: reset clears the chain output
    a_r10_chain_reset: assert property (@(posedge clk)
        !rst_n |=> !chain_o);

endmodule

// File: rtl/cfg_load_port.sv
// Module: top of the slave configuration load port.
// Ties the mode capture, input qualification, configuration store and
// chain output together.
// Assumes: all inputs are synchronous to clk; CFG_BITS is a multiple of 8.
module cfg_load_port
    import cfg_load_pkg::*;
#(
    parameter int CFG_BITS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_par_i,
    input  logic                swap_i,
    input  logic                ser_din_i,
    input  logic [7:0]          par_din_i,
    input  logic                wr_n_i,
    input  logic                cs0_n_i,
    input  logic                cs1_i,
    output logic                chain_o,
    output logic                done_o,
    output logic [CFG_BITS-1:0] cfg_data_o
);

    load_mode_e        mode_q;
    logic              swap_q;
    logic              accept;
    logic [BYTE_W-1:0] word;

    cfg_mode_latch u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_par_i (mode_par_i),
        .swap_i     (swap_i),
        .mode_o     (mode_q),
        .swap_o     (swap_q)
    );

    cfg_front u_front (
        .mode_i    (mode_q),
        .swap_i    (swap_q),
        .done_i    (done_o),
        .ser_din_i (ser_din_i),
        .par_din_i (par_din_i),
        .wr_n_i    (wr_n_i),
        .cs0_n_i   (cs0_n_i),
        .cs1_i     (cs1_i),
        .accept_o  (accept),
        .word_o    (word)
    );

    cfg_shift_store #(.CFG_BITS(CFG_BITS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode_q),
        .accept_i (accept),
        .word_i   (word),
        .store_o  (cfg_data_o),
        .done_o   (done_o)
    );

    cfg_chain_out u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_q),
        .done_i    (done_o),
        .ser_din_i (ser_din_i),
        .chain_o   (chain_o)
    );

    // R3: an unqualified byte-mode edge leaves the store unchanged
    a_r3_unselected_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PAR && (wr_n_i || cs0_n_i || !cs1_i)) |=> $stable(cfg_data_o));

endmodule

// File: tb/cfg_load_port_tb.sv
// Directed bench for the configuration load port; one task per scenario.
module cfg_load_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_par_i = 1'b0;
    logic          swap_i = 1'b0;
    logic          ser_din_i = 1'b0;
    logic [7:0]    par_din_i = 8'h00;
    logic          wr_n_i = 1'b1;
    logic          cs0_n_i = 1'b1;
    logic          cs1_i = 1'b0;
    logic          chain_o;
    logic          done_o;
    logic [NB-1:0] cfg_data_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_load_port #(.CFG_BITS(NB)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_par_i (mode_par_i),
        .swap_i     (swap_i),
        .ser_din_i  (ser_din_i),
        .par_din_i  (par_din_i),
        .wr_n_i     (wr_n_i),
        .cs0_n_i    (cs0_n_i),
        .cs1_i      (cs1_i),
        .chain_o    (chain_o),
        .done_o     (done_o),
        .cfg_data_o (cfg_data_o)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [NB-1:0] act, input logic [NB-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock: inputs already set at a negedge; sample at the next negedge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    task automatic do_reset(input logic par, input logic swp);
        rst_n = 1'b0; mode_par_i = par; swap_i = swp;
        wr_n_i = 1'b1; cs0_n_i = 1'b1; cs1_i = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b);
        par_din_i = b; wr_n_i = 1'b0; cs0_n_i = 1'b0; cs1_i = 1'b1;
        step();
        wr_n_i = 1'b1; cs0_n_i = 1'b1; cs1_i = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset(1'b0, 1'b0);
        check(done_o == 1'b0 && chain_o == 1'b0 && cfg_data_o == '0, "R10", "reset state",
              {cfg_data_o[NB-3:0], done_o, chain_o}, '0);
    endtask

    task automatic t_serial_load();
        logic [NB-1:0] exp = '0;
        logic          chain_bad = 1'b0;
        logic          b;
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < NB; i++) begin
            b = ((i * 7 + 3) % 5 < 2) ^ (i[3]);
            ser_din_i = b;
            exp = {exp[NB-2:0], b};
            step();
            if (i == NB - 2) check(done_o == 1'b0, "R5", "serial done early", done_o, 0);
            if (chain_o) chain_bad = 1'b1;
        end
        check(done_o == 1'b1, "R5", "serial done", done_o, 1);
        check(cfg_data_o == exp, "R1", "serial store", cfg_data_o, exp);
        check(!chain_bad, "R7", "chain low before done", chain_bad, 0);
        for (int k = 0; k < 6; k++) begin
            b = (k % 3 != 1);
            ser_din_i = b;
            step();
            check(chain_o == b, "R7", "passthrough bit", chain_o, b);
        end
        check(cfg_data_o == exp, "R6", "store frozen after done", cfg_data_o, exp);
        check(done_o == 1'b1, "R5", "done stays high", done_o, 1);
    endtask

    task automatic t_parallel_load(input logic swp);
        logic [NB-1:0] exp = '0;
        logic [NB-1:0] snap;
        logic [7:0]    b;
        logic          chain_bad = 1'b0;
        do_reset(1'b1, swp);
        for (int i = 0; i < NB / 8; i++) begin
            b = 8'h13 + 8'(i * 37);
            send_byte(b);
            exp = {exp[NB-9:0], swp ? rev8(b) : b};
            if (chain_o) chain_bad = 1'b1;
            if (i < NB / 8 - 1) begin
                snap = cfg_data_o;
                // each select inactive in turn, with live data on the bus
                par_din_i = 8'hA5; ser_din_i = 1'b1;
                wr_n_i = 1'b1; cs0_n_i = 1'b0; cs1_i = 1'b1; step();
                wr_n_i = 1'b0; cs0_n_i = 1'b1; cs1_i = 1'b1; step();
                wr_n_i = 1'b0; cs0_n_i = 1'b0; cs1_i = 1'b0; step();
                wr_n_i = 1'b1; cs0_n_i = 1'b1; cs1_i = 1'b0;
                if (chain_o) chain_bad = 1'b1;
                if (i == 1) check(cfg_data_o == snap, "R3", "unselected edges ignored", cfg_data_o, snap);
                if (i == NB / 8 - 2) check(done_o == 1'b0, "R5", "byte done early", done_o, 0);
            end
        end
        check(done_o == 1'b1, "R5", "byte done", done_o, 1);
        if (swp) check(cfg_data_o == exp, "R4", "mirrored store", cfg_data_o, exp);
        else     check(cfg_data_o == exp, "R2", "byte store", cfg_data_o, exp);
        ser_din_i = 1'b1; step();
        check(!chain_bad && chain_o == 1'b0, "R8", "chain low in byte mode", chain_o, 0);
    endtask

    task automatic t_mode_latched();
        do_reset(1'b0, 1'b0);
        mode_par_i = 1'b1;
        par_din_i = 8'h00; ser_din_i = 1'b1;
        wr_n_i = 1'b0; cs0_n_i = 1'b0; cs1_i = 1'b1;
        step();
        wr_n_i = 1'b1; cs0_n_i = 1'b1; cs1_i = 1'b0;
        check(cfg_data_o == 64'h1, "R9", "mode change after reset ignored", cfg_data_o, 64'h1);
        do_reset(1'b1, 1'b0);
        swap_i = 1'b1;
        send_byte(8'h01);
        check(cfg_data_o == 64'h01, "R9", "swap change after reset ignored", cfg_data_o, 64'h01);
    endtask

    task automatic t_reset_mid();
        do_reset(1'b0, 1'b0);
        ser_din_i = 1'b1;
        for (int i = 0; i < 10; i++) step();
        rst_n = 1'b0; step(); rst_n = 1'b1;
        check(cfg_data_o == '0 && done_o == 1'b0, "R10", "reset mid load", cfg_data_o, '0);
        for (int i = 0; i < NB + 2; i++) step();
        check(done_o == 1'b1 && chain_o == 1'b1, "R7", "reload then pass", {done_o, chain_o}, 2'b11);
        rst_n = 1'b0; step(); rst_n = 1'b1;
        check(done_o == 1'b0 && chain_o == 1'b0, "R10", "reset after done", {done_o, chain_o}, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_serial_load();
        t_parallel_load(1'b0);
        t_parallel_load(1'b1);
        t_mode_latched();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule